// File: doc/BRIEF.md
# Prioritised Serial Interrupt Identification

This block sits beside the receive and transmit engines of a serial port and turns their event conditions into one interrupt request and a readable identification byte. Five sources are tracked: receive line errors, received data ready, receive character timeout, transmitter holding register empty, and modem line change. Each source has its own pending latch. A four-bit enable register masks the latches, and a fixed priority encoder reports the most urgent enabled source as a three-bit code.

Software reads the identification byte to learn what to service. It then performs the access that services that source, and this access clears the matching latch. The block observes those accesses through read and write strobes for the line status, receive data, modem status, identification and transmit data registers. The character timeout source only counts while FIFO mode is on. The transmit-empty source is special: reading the identification byte while it is the reported source acknowledges it.

Top module: `serial_irq_ident`

## Requirements
- R1: The enable register resets to 0. A write strobe loads wrData[3:0], and the enable byte reads these four bits with bits 7..4 always 0. Bit 0 enables received data and timeout, bit 1 transmit empty, bit 2 line error, bit 3 modem change.
- R2: Identification bit 0 reads 1 when no enabled source is pending and 0 otherwise. After reset with FIFO mode off the byte is 0x01.
- R3: Identification bits 7..6 read 11 while fifoEn is high and 00 while it is low. Bits 5..4 always read 0.
- R4: Bits 3..1 give the highest-priority enabled pending source. From highest to lowest priority the codes are: line error 011, received data 010, character timeout 110, transmit empty 001, modem change 000.
- R5: A pending line error is cleared by a line status read. A new error in the same cycle as that read stays pending.
- R6: Received data and character timeout are both cleared by a receive data read.
- R7: A timeout event is latched only while fifoEn is high. A pending timeout is discarded, and never reported, while fifoEn is low.
- R8: An identification read clears transmit empty only while transmit empty is the reported source. The same read leaves it pending when a higher source is reported.
- R9: A transmit data write clears a pending transmit empty.
- R10: Transmit empty becomes pending when thrEmpty goes from 0 to 1. It also becomes pending when enable bit 1 goes from 0 to 1 while thrEmpty is high.
- R11: A pending modem change is cleared by a modem status read.
- R12: irq is high exactly when some enabled source is pending and irqGate is high.
- R13: Sources latch regardless of their enable bit. A masked pending source is reported as soon as its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineErr | input | 1 | Pulse: receive line error detected |
| rxRdy | input | 1 | Pulse: received data became available |
| rxTimeout | input | 1 | Pulse: receive FIFO idle-timeout elapsed |
| thrEmpty | input | 1 | Level: transmit holding register empty |
| modemChg | input | 1 | Pulse: a modem input line changed |
| fifoEn | input | 1 | FIFO mode active |
| irqGate | input | 1 | Output gate for the interrupt request |
| rdIir | input | 1 | Identification register read strobe |
| rdLsr | input | 1 | Line status register read strobe |
| rdRbr | input | 1 | Receive data register read strobe |
| rdMsr | input | 1 | Modem status register read strobe |
| wrThr | input | 1 | Transmit data register write strobe |
| wrIer | input | 1 | Enable register write strobe |
| wrData | input | 8 | Write data for the enable register |
| iirOut | output | 8 | Identification byte |
| ierOut | output | 8 | Enable register contents |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked on every cycle. These cover the fixed zero bits of the enable byte, the FIFO-mode bits of the identification byte, and the agreement between irq and the no-pending bit under the gate. They also cover the absence of a timeout code outside FIFO mode, and the clearing of line, modem and transmit-empty sources after their servicing access when no new event arrives at once. Other behaviour needs the bench's scenarios and its reference model: the full priority order, whether a source wins or loses when it is set and cleared in the same cycle, the conditional acknowledge by identification read, the two ways transmit empty re-arms, and sources that were latched while masked.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int SRC_N = 5;
  localparam int IDX_W = $clog2(SRC_N);

  // source index doubles as priority rank, 0 is most urgent
  localparam int SRC_LINE = 0;
  localparam int SRC_RXD  = 1;
  localparam int SRC_TMO  = 2;
  localparam int SRC_THRE = 3;
  localparam int SRC_MDM  = 4;

  localparam int EN_RXD  = 0;
  localparam int EN_THRE = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MDM  = 3;

  typedef struct packed {
    logic [SRC_N-1:0] setVec;
    logic [SRC_N-1:0] clrVec;
    logic             ierLoad;
  } strobe_t;

  function automatic logic [2:0] srcCode(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(SRC_LINE): srcCode = 3'b011;
      IDX_W'(SRC_RXD):  srcCode = 3'b010;
      IDX_W'(SRC_TMO):  srcCode = 3'b110;
      IDX_W'(SRC_THRE): srcCode = 3'b001;
      default:          srcCode = 3'b000;
    endcase
  endfunction

  function automatic int srcEnBit(input int idx);
    case (idx)
      SRC_LINE: srcEnBit = EN_LINE;
      SRC_RXD:  srcEnBit = EN_RXD;
      SRC_TMO:  srcEnBit = EN_RXD;
      SRC_THRE: srcEnBit = EN_THRE;
      default:  srcEnBit = EN_MDM;
    endcase
  endfunction
endpackage

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineErr,
  input  logic             rxRdy,
  input  logic             rxTimeout,
  input  logic             thrEmpty,
  input  logic             modemChg,
  input  logic             fifoEn,
  input  logic             rdIir,
  input  logic             rdLsr,
  input  logic             rdRbr,
  input  logic             rdMsr,
  input  logic             wrThr,
  input  logic             wrIer,
  input  logic             threEnNew,
  input  logic             threEnQ,
  input  logic [IDX_W-1:0] topIdx,
  input  logic             anyActive,
  output strobe_t          strobe
);
  logic thrPrev;
  logic thrRise;
  logic threArm;
  logic threAck;

  // holding register assumed empty out of reset: no spurious edge
  always_ff @(posedge clk) begin
    if (!rstN) thrPrev <= 1'b1;
    else       thrPrev <= thrEmpty;
  end

  assign thrRise = thrEmpty & ~thrPrev;
  assign threArm = wrIer & threEnNew & ~threEnQ & thrEmpty;
  assign threAck = rdIir & anyActive & (topIdx == IDX_W'(SRC_THRE));

  always_comb begin
    strobe = '0;
    strobe.ierLoad = wrIer;

    strobe.setVec[SRC_LINE] = lineErr;
    strobe.clrVec[SRC_LINE] = rdLsr;

    strobe.setVec[SRC_RXD]  = rxRdy;
    strobe.clrVec[SRC_RXD]  = rdRbr;

    strobe.setVec[SRC_TMO]  = rxTimeout & fifoEn;
    strobe.clrVec[SRC_TMO]  = rdRbr | ~fifoEn;

    strobe.setVec[SRC_THRE] = thrRise | threArm;
    strobe.clrVec[SRC_THRE] = wrThr | threAck;

    strobe.setVec[SRC_MDM]  = modemChg;
    strobe.clrVec[SRC_MDM]  = rdMsr;
  end
endmodule

// File: rtl/sirq_datapath.sv
module sirq_datapath
  import sirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EN_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [EN_W-1:0]   wrEn,
  input  logic              fifoEn,
  output logic [EN_W-1:0]   ierQ,
  output logic [IDX_W-1:0]  topIdx,
  output logic              anyActive,
  output logic [DATA_W-1:0] iirByte,
  output logic [DATA_W-1:0] ierByte
);
  localparam int PAD_W = DATA_W - EN_W;

  logic [SRC_N-1:0] pendQ;
  logic [SRC_N-1:0] activeVec;

  always_ff @(posedge clk) begin
    if (!rstN)               ierQ <= '0;
    else if (strobe.ierLoad) ierQ <= wrEn;
  end

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    localparam int EB = srcEnBit(s);
    // new event outranks a servicing access in the same cycle
    always_ff @(posedge clk) begin
      if (!rstN) pendQ[s] <= 1'b0;
      else       pendQ[s] <= strobe.setVec[s] | (pendQ[s] & ~strobe.clrVec[s]);
    end
    if (s == SRC_TMO) begin : g_fifoGated
      assign activeVec[s] = pendQ[s] & ierQ[EB] & fifoEn;
    end else begin : g_plain
      assign activeVec[s] = pendQ[s] & ierQ[EB];
    end
  end

  always_comb begin
    topIdx = IDX_W'(SRC_MDM);
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (activeVec[i]) topIdx = IDX_W'(i);
    end
  end

  assign anyActive = |activeVec;

  always_comb begin
    iirByte = '0;
    iirByte[DATA_W-1 -: 2] = {2{fifoEn}};
    iirByte[3:1] = anyActive ? srcCode(topIdx) : 3'b000;
    iirByte[0] = ~anyActive;
  end

  assign ierByte = {{PAD_W{1'b0}}, ierQ};
endmodule

// File: rtl/serial_irq_ident.sv
module serial_irq_ident
  import sirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EN_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineErr,
  input  logic              rxRdy,
  input  logic              rxTimeout,
  input  logic              thrEmpty,
  input  logic              modemChg,
  input  logic              fifoEn,
  input  logic              irqGate,
  input  logic              rdIir,
  input  logic              rdLsr,
  input  logic              rdRbr,
  input  logic              rdMsr,
  input  logic              wrThr,
  input  logic              wrIer,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] iirOut,
  output logic [DATA_W-1:0] ierOut,
  output logic              irq
);
  strobe_t          strobe;
  logic [EN_W-1:0]  ierQ;
  logic [IDX_W-1:0] topIdx;
  logic             anyActive;
  logic             unusedHi;

  assign unusedHi = ^wrData[DATA_W-1:EN_W];

  sirq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lineErr   (lineErr),
    .rxRdy     (rxRdy),
    .rxTimeout (rxTimeout),
    .thrEmpty  (thrEmpty),
    .modemChg  (modemChg),
    .fifoEn    (fifoEn),
    .rdIir     (rdIir),
    .rdLsr     (rdLsr),
    .rdRbr     (rdRbr),
    .rdMsr     (rdMsr),
    .wrThr     (wrThr),
    .wrIer     (wrIer),
    .threEnNew (wrData[EN_THRE]),
    .threEnQ   (ierQ[EN_THRE]),
    .topIdx    (topIdx),
    .anyActive (anyActive),
    .strobe    (strobe)
  );

  sirq_datapath #(.DATA_W(DATA_W), .EN_W(EN_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrEn      (wrData[EN_W-1:0]),
    .fifoEn    (fifoEn),
    .ierQ      (ierQ),
    .topIdx    (topIdx),
    .anyActive (anyActive),
    .iirByte   (iirOut),
    .ierByte   (ierOut)
  );

  assign irq = anyActive & irqGate;
endmodule

// File: rtl/sirq_chk.sv
module sirq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       lineErr,
  input logic       thrEmpty,
  input logic       modemChg,
  input logic       fifoEn,
  input logic       irqGate,
  input logic       rdLsr,
  input logic       rdMsr,
  input logic       wrThr,
  input logic [7:0] iirOut,
  input logic [7:0] ierOut,
  input logic       irq
);
  // R1
  ier_high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ierOut[7:4] == 4'h0);

  // R3
  fifo_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    iirOut[7:6] == {2{fifoEn}} && iirOut[5:4] == 2'b00);

  // R12
  irq_matches_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqGate |-> (irq == !iirOut[0]));

  // R12
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqGate |-> !irq);

  // R7
  no_timeout_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |-> !(iirOut[0] == 1'b0 && iirOut[3:1] == 3'b110));

  // R5
  line_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdLsr && !lineErr) |=> !(iirOut[0] == 1'b0 && iirOut[3:1] == 3'b011));

  // R11
  modem_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdMsr && !modemChg) |=> !(iirOut[0] == 1'b0 && iirOut[3:1] == 3'b000));

  // R9
  thre_write_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrThr && !thrEmpty) |=> !(iirOut[0] == 1'b0 && iirOut[3:1] == 3'b001));
endmodule

bind serial_irq_ident sirq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lineErr  (lineErr),
  .thrEmpty (thrEmpty),
  .modemChg (modemChg),
  .fifoEn   (fifoEn),
  .irqGate  (irqGate),
  .rdLsr    (rdLsr),
  .rdMsr    (rdMsr),
  .wrThr    (wrThr),
  .iirOut   (iirOut),
  .ierOut   (ierOut),
  .irq      (irq)
);

// File: tb/sim_serial_irq_ident.sv
`timescale 1ns/1ps
module sim_serial_irq_ident;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineErr = 0, rxRdy = 0, rxTimeout = 0, thrEmpty = 1, modemChg = 0;
  logic       fifoEn = 0, irqGate = 1;
  logic       rdIir = 0, rdLsr = 0, rdRbr = 0, rdMsr = 0, wrThr = 0, wrIer = 0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] iirOut, ierOut;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_irq_ident u0 (
    .clk(clk), .rstN(rstN), .lineErr(lineErr), .rxRdy(rxRdy), .rxTimeout(rxTimeout),
    .thrEmpty(thrEmpty), .modemChg(modemChg), .fifoEn(fifoEn), .irqGate(irqGate),
    .rdIir(rdIir), .rdLsr(rdLsr), .rdRbr(rdRbr), .rdMsr(rdMsr), .wrThr(wrThr),
    .wrIer(wrIer), .wrData(wrData), .iirOut(iirOut), .ierOut(ierOut), .irq(irq)
  );

  // reference model: pend index 0 line, 1 rx, 2 timeout, 3 thre, 4 modem
  logic [4:0] mPend;
  logic [3:0] mIer;
  logic       mThrPrev;

  function automatic logic [4:0] mAct(logic [4:0] p, logic [3:0] e, logic f);
    return {p[4] & e[3], p[3] & e[1], p[2] & e[0] & f, p[1] & e[0], p[0] & e[2]};
  endfunction

  function automatic logic [7:0] mIir(logic [4:0] p, logic [3:0] e, logic f);
    logic [4:0] a;
    logic [7:0] b;
    a = mAct(p, e, f);
    b = f ? 8'hC0 : 8'h00;
    if (a[0])      return b | 8'h06;
    else if (a[1]) return b | 8'h04;
    else if (a[2]) return b | 8'h0C;
    else if (a[3]) return b | 8'h02;
    else if (a[4]) return b;
    return b | 8'h01;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPend    <= '0;
      mIer     <= '0;
      mThrPrev <= 1'b1;
    end else begin
      logic thrSet, thrClr;
      logic [7:0] cur;
      cur    = mIir(mPend, mIer, fifoEn);
      thrSet = (thrEmpty & ~mThrPrev) | (wrIer & wrData[1] & ~mIer[1] & thrEmpty);
      thrClr = wrThr | (rdIir && cur[3:0] == 4'h2);
      mPend[0] <= lineErr | (mPend[0] & ~rdLsr);
      mPend[1] <= rxRdy | (mPend[1] & ~rdRbr);
      mPend[2] <= (rxTimeout & fifoEn) | (mPend[2] & ~rdRbr & fifoEn);
      mPend[3] <= thrSet | (mPend[3] & ~thrClr);
      mPend[4] <= modemChg | (mPend[4] & ~rdMsr);
      if (wrIer) mIer <= wrData[3:0];
      mThrPrev <= thrEmpty;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpModel();
    logic [7:0] e;
    e = mIir(mPend, mIer, fifoEn);
    chk("R1 ier model", ierOut, {4'h0, mIer});
    chk("R3 iir top bits", {6'h0, iirOut[7:6]}, {6'h0, e[7:6]});
    chk("R4 iir model", iirOut, e);
    chk("R12 irq model", {7'h0, irq}, {7'h0, (e[0] == 1'b0) & irqGate});
  endtask

  // one clock: inputs set by caller take effect, check after the edge
  task automatic step();
    @(negedge clk);
    cmpModel();
    lineErr = 0; rxRdy = 0; rxTimeout = 0; modemChg = 0;
    rdIir = 0; rdLsr = 0; rdRbr = 0; rdMsr = 0; wrThr = 0; wrIer = 0;
  endtask

  task automatic writeIer(logic [7:0] v);
    wrIer = 1; wrData = v; step();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    step();
    chk("R2 reset iir", iirOut, 8'h01);
    chk("R1 reset ier", ierOut, 8'h00);
    chk("R12 reset irq", {7'h0, irq}, 8'h00);

    writeIer(8'hA5);
    chk("R1 upper bits dropped", ierOut, 8'h05);
    writeIer(8'h00);
    writeIer(8'hFF);
    chk("R1 ier all", ierOut, 8'h0F);
    chk("R10 enable rearm", iirOut, 8'h02);
    rdIir = 1; step();
    chk("R8 iir read ack", iirOut, 8'h01);

    lineErr = 1; rxRdy = 1; modemChg = 1; step();
    chk("R4 line highest", iirOut, 8'h06);
    rdLsr = 1; step();
    chk("R5 line cleared", iirOut, 8'h04);
    rdRbr = 1; step();
    chk("R6 rx cleared", iirOut, 8'h00);
    rdMsr = 1; step();
    chk("R11 modem cleared", iirOut, 8'h01);

    lineErr = 1; step();
    lineErr = 1; rdLsr = 1; step();
    chk("R5 set wins", iirOut, 8'h06);
    rdLsr = 1; step();

    thrEmpty = 0; step();
    chk("R10 no edge", iirOut, 8'h01);
    thrEmpty = 1; step();
    chk("R10 rising edge", iirOut, 8'h02);
    lineErr = 1; step();
    rdIir = 1; step();
    chk("R8 higher reported", iirOut, 8'h06);
    rdLsr = 1; step();
    chk("R8 thre kept", iirOut, 8'h02);
    wrThr = 1; step();
    chk("R9 write clears", iirOut, 8'h01);

    rxTimeout = 1; step();
    chk("R7 ignored fifo off", iirOut, 8'h01);
    fifoEn = 1; step();
    chk("R3 fifo bits", iirOut, 8'hC1);
    rxTimeout = 1; step();
    chk("R4 timeout code", iirOut, 8'hCC);
    rxRdy = 1; step();
    chk("R4 rx over timeout", iirOut, 8'hC4);
    rdRbr = 1; step();
    chk("R6 both cleared", iirOut, 8'hC1);
    rxTimeout = 1; step();
    fifoEn = 0; step();
    chk("R7 discarded", iirOut, 8'h01);
    fifoEn = 1; step();
    chk("R7 stays discarded", iirOut, 8'hC1);
    fifoEn = 0;

    writeIer(8'h00);
    modemChg = 1; step();
    chk("R13 masked", iirOut, 8'h01);
    chk("R13 masked irq", {7'h0, irq}, 8'h00);
    writeIer(8'h08);
    chk("R13 unmasked", iirOut, 8'h00);
    chk("R12 irq on", {7'h0, irq}, 8'h01);
    irqGate = 0; step();
    chk("R12 gate off", {7'h0, irq}, 8'h00);
    irqGate = 1; rdMsr = 1; step();

    for (int n = 0; n < 5000; n++) begin
      lineErr   = ($urandom % 16) == 0;
      rxRdy     = ($urandom % 10) == 0;
      rxTimeout = ($urandom % 12) == 0;
      modemChg  = ($urandom % 14) == 0;
      rdIir     = ($urandom % 4) == 0;
      rdLsr     = ($urandom % 8) == 0;
      rdRbr     = ($urandom % 8) == 0;
      rdMsr     = ($urandom % 8) == 0;
      wrThr     = ($urandom % 9) == 0;
      wrIer     = ($urandom % 20) == 0;
      wrData    = 8'($urandom);
      if (($urandom % 6) == 0)  thrEmpty = ~thrEmpty;
      if (($urandom % 50) == 0) fifoEn = ~fifoEn;
      if (($urandom % 40) == 0) irqGate = ~irqGate;
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule